// File: doc/BRIEF.md
# Sticky Interrupt Flag Bank

This block holds sixteen numbered interrupt flags. Each flag latches a one-cycle event pulse from its peripheral. A plain write cannot drop it. Software first reads the status register and sees the flag at 1. It then makes the access that belongs to that source. Only that access releases the flag. Depending on the source, the access is a write of 0 to the flag bit, a write to the port's control address, or an access to a data address. The data access is a write for transmit flags, a read for receive flags, and either for the shift-port completion flag.

Each source has its own enable bit. The enable gates only that source's request line. A flag that was recorded while its source was disabled raises its request as soon as software enables it. A combined request line ORs all enabled pending flags. Priority, vectoring and the peripherals are outside this block. Reads of the peripheral addresses return 0 here, because the block only watches those accesses.

Top module: `irq_flag_bank`

## Requirements
- R1: After a synchronous active-low reset, all flags, arm bits and enable bits are 0, and every request output is 0.
- R2: An event pulse on `evt_i[k]` sets flag k at the next clock edge. A read at address 0 returns the flag vector with bit k holding source k.
- R3: Address 1 is the enable register, which is read/write with bit k belonging to source k. `irq_o[k]` equals flag k AND enable k. Flags are recorded while disabled, and a pending flag drives its request as soon as its enable is set.
- R4: `irq_any_o` is 1 exactly when at least one `irq_o` bit is 1.
- R5: Sources 0 to 3 clear when address 0 is written with their bit at 0 while armed. A bit written as 1 leaves its flag unchanged.
- R6: Source 4 clears on a write to address 2 while armed.
- R7: Source 5 clears on any read or write of address 3 while armed.
- R8: Transmit sources 6 and 7 clear on a write to address 4 while armed. Transmit sources 11 and 12 clear on a write to address 5 while armed.
- R9: Receive sources 8 to 10 clear on a read of address 4 while armed. Receive sources 13 to 15 clear on a read of address 5 while armed.
- R10: A flag is armed only by a status read that returns it as 1. A qualifying access to an unarmed flag leaves the flag at 1. A status read while the flag is 0 does not arm it.
- R11: When a set event and an armed qualifying access meet in one cycle, the flag stays 1 and its arm bit is cleared.
- R12: A completed clear also clears the arm bit. A later set followed by a qualifying access without a new status read leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_SRC | One-cycle set pulses, one per source |
| bus_valid_i | input | 1 | Register access this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | NUM_SRC | Write data |
| bus_rdata_o | output | NUM_SRC | Read data for the current address (combinational) |
| irq_o | output | NUM_SRC | Per-source gated request |
| irq_any_o | output | 1 | OR of all gated requests |

## Verification
Several rules are checked on every cycle by the assertions in the flag cells. A set pulse always leaves the flag at 1. An unarmed flag never falls. An arm bit never exists without its flag. A falling flag never leaves an arm behind. Set-versus-clear collisions keep the flag and drop the arm. The assertions cannot show that each source answers to the right address and direction. They also cannot show that the two-step order is needed across separate cycles. The bench shows both through directed sequences and a pseudo-random phase, each compared against a behavioural model on every clock.

// File: rtl/irq_flag_pkg.sv
// Package: register addresses and per-source clear-rule tables for the flag bank.
// Assumes a 3-bit register address space and at most 16 mapped sources;
// any higher source index falls back to the write-zero rule on the status address.
package irq_flag_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_STATUS     = 3'd0;
    localparam logic [ADDR_W-1:0] REG_ENABLE     = 3'd1;
    localparam logic [ADDR_W-1:0] REG_SPORT_CTRL = 3'd2;
    localparam logic [ADDR_W-1:0] REG_SPORT_DATA = 3'd3;
    localparam logic [ADDR_W-1:0] REG_CHA_DATA   = 3'd4;
    localparam logic [ADDR_W-1:0] REG_CHB_DATA   = 3'd5;

    // Which access completes the clear of an armed flag
    typedef enum logic [2:0] {
        CLR_WR_ZERO  = 3'd0,   // write 0 to the flag bit on the status address
        CLR_CTRL_WR  = 3'd1,   // write to the owning control address
        CLR_DATA_ANY = 3'd2,   // read or write of the owning data address
        CLR_CH_WR    = 3'd3,   // write to the owning channel data address
        CLR_CH_RD    = 3'd4    // read of the owning channel data address
    } clr_kind_e;

    // Clear rule of a source index
    function automatic clr_kind_e src_kind(input int idx);
        case (idx)
            4:                 return CLR_CTRL_WR;
            5:                 return CLR_DATA_ANY;
            6, 7, 11, 12:      return CLR_CH_WR;
            8, 9, 10,
            13, 14, 15:        return CLR_CH_RD;
            default:           return CLR_WR_ZERO;
        endcase
    endfunction

    // Register address whose access completes the clear of a source
    function automatic logic [ADDR_W-1:0] src_reg(input int idx);
        if (idx == 4)                    return REG_SPORT_CTRL;
        else if (idx == 5)               return REG_SPORT_DATA;
        else if (idx >= 6 && idx <= 10)  return REG_CHA_DATA;
        else if (idx >= 11 && idx <= 15) return REG_CHB_DATA;
        else                             return REG_STATUS;
    endfunction

endpackage

// File: rtl/irq_access_decode.sv
// Module: decodes one register access into a status-read strobe, an enable
// write strobe and a per-source "qualifying access" vector.
// Assumes at most one access per cycle; the clear rule of each source is
// fixed at elaboration from the package tables.
module irq_access_decode
    import irq_flag_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                bus_valid_i,
    input  logic                bus_write_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [NUM_SRC-1:0]  bus_wdata_i,
    output logic                status_rd_o,
    output logic                enable_wr_o,
    output logic [NUM_SRC-1:0]  qual_o
);

    logic rd_s;
    logic wr_s;

    // Split the access into read and write strobes
    always_comb begin
        rd_s        = bus_valid_i && !bus_write_i;
        wr_s        = bus_valid_i &&  bus_write_i;
        status_rd_o = rd_s && (bus_addr_i == REG_STATUS);
        enable_wr_o = wr_s && (bus_addr_i == REG_ENABLE);
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_qual
        localparam clr_kind_e         KIND = src_kind(k);
        localparam logic [ADDR_W-1:0] OWN  = src_reg(k);
        if (KIND == CLR_WR_ZERO) begin : g_wz
            // Write with this bit at 0 on the status address
            always_comb qual_o[k] = wr_s && (bus_addr_i == REG_STATUS) && !bus_wdata_i[k];
        end else if (KIND == CLR_CTRL_WR || KIND == CLR_CH_WR) begin : g_wr
            // Write to the owning address
            always_comb qual_o[k] = wr_s && (bus_addr_i == OWN);
        end else if (KIND == CLR_DATA_ANY) begin : g_any
            // Any access to the owning address
            always_comb qual_o[k] = bus_valid_i && (bus_addr_i == OWN);
        end else begin : g_rd
            // Read of the owning address
            always_comb qual_o[k] = rd_s && (bus_addr_i == OWN);
        end
    end

endmodule

// File: rtl/irq_flag_cell.sv
// Module: one sticky flag with its arm bit.
// Assumes set_i is a one-cycle pulse, status_rd_i marks a status read in this
// cycle, and qual_i marks this source's qualifying access in this cycle.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic status_rd_i,
    input  logic qual_i,
    output logic flag_o
);

    logic flag_q;
    logic arm_q;
    logic clr_hit;

    // An armed flag meets its qualifying access
    always_comb clr_hit = qual_i && arm_q;

    // Flag and arm update: set beats clear, a clear attempt always disarms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else if (clr_hit) begin
            flag_q <= set_i;
            arm_q  <= 1'b0;
        end else begin
            flag_q <= flag_q || set_i;
            arm_q  <= arm_q || (status_rd_i && flag_q);
        end
    end

    assign flag_o = flag_q;

    // R2
    property set_sticks_p;
        @(posedge clk) disable iff (!rst_n) set_i |=> flag_q;
    endproperty
    set_sticks_chk: assert property (set_sticks_p);

    // R10
    property unarmed_holds_p;
        @(posedge clk) disable iff (!rst_n) (flag_q && !arm_q) |=> flag_q;
    endproperty
    unarmed_holds_chk: assert property (unarmed_holds_p);

    // R10
    property arm_needs_flag_p;
        @(posedge clk) disable iff (!rst_n) arm_q |-> flag_q;
    endproperty
    arm_needs_flag_chk: assert property (arm_needs_flag_p);

    // R12
    property fall_disarms_p;
        @(posedge clk) disable iff (!rst_n) $fell(flag_q) |-> !arm_q;
    endproperty
    fall_disarms_chk: assert property (fall_disarms_p);

    // R11
    property collide_p;
        @(posedge clk) disable iff (!rst_n) (set_i && qual_i && arm_q) |=> (flag_q && !arm_q);
    endproperty
    collide_chk: assert property (collide_p);

endmodule

// File: rtl/irq_flag_bank.sv
// Module: top of the sticky interrupt flag bank. Holds the enable register,
// the read-data mux and the request outputs; instantiates one flag cell per source.
// Assumes one register access per cycle; peripheral addresses read back as 0.
module irq_flag_bank
    import irq_flag_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  evt_i,
    input  logic                bus_valid_i,
    input  logic                bus_write_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [NUM_SRC-1:0]  bus_wdata_i,
    output logic [NUM_SRC-1:0]  bus_rdata_o,
    output logic [NUM_SRC-1:0]  irq_o,
    output logic                irq_any_o
);

    logic               status_rd;
    logic               enable_wr;
    logic [NUM_SRC-1:0] qual;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] en_q;

    irq_access_decode #(.NUM_SRC(NUM_SRC)) u_decode (
        .bus_valid_i (bus_valid_i),
        .bus_write_i (bus_write_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .status_rd_o (status_rd),
        .enable_wr_o (enable_wr),
        .qual_o      (qual)
    );

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_cell
        irq_flag_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_i       (evt_i[k]),
            .status_rd_i (status_rd),
            .qual_i      (qual[k]),
            .flag_o      (flags[k])
        );
    end

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= '0;
        else if (enable_wr) en_q <= bus_wdata_i;
    end

    // Read-data mux by address
    always_comb begin
        case (bus_addr_i)
            REG_STATUS: bus_rdata_o = flags;
            REG_ENABLE: bus_rdata_o = en_q;
            default:    bus_rdata_o = '0;
        endcase
    end

    // Gated and combined requests
    always_comb begin
        irq_o     = flags & en_q;
        irq_any_o = |irq_o;
    end

    // R3
    property disable_all_p;
        @(posedge clk) disable iff (!rst_n) (enable_wr && (bus_wdata_i == '0)) |=> !irq_any_o;
    endproperty
    disable_all_chk: assert property (disable_all_p);

endmodule

// File: tb/irq_flag_bank_tb.sv
module irq_flag_bank_tb;

    localparam int PERIOD = 10;
    localparam int N      = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  evt;
    logic          bv, bw;
    logic [2:0]    ba;
    logic [N-1:0]  bwd;
    logic [N-1:0]  rdata, irq;
    logic          irq_any;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural model state
    bit        m_flag [N];
    bit        m_arm  [N];
    logic [N-1:0] m_en;
    logic [N-1:0] last_rd;

    always #(PERIOD/2) clk = ~clk;

    irq_flag_bank #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .bus_valid_i(bv), .bus_write_i(bw), .bus_addr_i(ba), .bus_wdata_i(bwd),
        .bus_rdata_o(rdata), .irq_o(irq), .irq_any_o(irq_any)
    );

    function automatic logic [N-1:0] m_flags();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_flag[i];
        return v;
    endfunction

    // qualifying access per the clear rules of R5..R9
    function automatic bit m_qual(int i, bit v, bit w, int a, logic [N-1:0] wd);
        int chan;
        bit tx;
        if (!v) return 0;
        if (i < 4)  return w && a == 0 && !wd[i];
        if (i == 4) return w && a == 2;
        if (i == 5) return a == 3;
        chan = (i < 11) ? 4 : 5;
        tx   = (i == 6 || i == 7 || i == 11 || i == 12);
        return a == chan && (tx ? w : !w);
    endfunction

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive, compare against model, advance model
    task automatic cyc(logic [N-1:0] e, bit v, bit w, int a, logic [N-1:0] wd);
        logic [N-1:0] exp_rd, exp_irq;
        bit nf [N];
        bit na [N];
        bit srd;
        evt = e; bv = v; bw = w; ba = 3'(a); bwd = wd;
        #(PERIOD/4);
        exp_irq = m_flags() & m_en;
        check("R3 irq", irq, exp_irq);
        check("R4 irq_any", {{(N-1){1'b0}}, irq_any}, {{(N-1){1'b0}}, |exp_irq});
        exp_rd = (a == 0) ? m_flags() : (a == 1) ? m_en : '0;
        if (v && !w) check("R2 rdata", rdata, exp_rd);
        last_rd = rdata;
        srd = v && !w && a == 0;
        for (int i = 0; i < N; i++) begin
            if (m_qual(i, v, w, a, wd) && m_arm[i]) begin
                nf[i] = e[i]; na[i] = 0;
            end else begin
                nf[i] = m_flag[i] || e[i];
                na[i] = m_arm[i] || (srd && m_flag[i]);
            end
        end
        @(posedge clk);
        for (int i = 0; i < N; i++) begin m_flag[i] = nf[i]; m_arm[i] = na[i]; end
        if (v && w && a == 1) m_en = wd;
        @(negedge clk);
    endtask

    task automatic idle();                         cyc('0, 0, 0, 0, '0); endtask
    task automatic rd(int a);                      cyc('0, 1, 0, a, '0); endtask
    task automatic wr(int a, logic [N-1:0] d);     cyc('0, 1, 1, a, d);  endtask
    task automatic pulse(logic [N-1:0] e);         cyc(e, 0, 0, 0, '0);  endtask
    task automatic expect_status(string tag, logic [N-1:0] exp);
        rd(0);
        check(tag, last_rd, exp);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        rst_n = 0; evt = '0; bv = 0; bw = 0; ba = '0; bwd = '0;
        for (int i = 0; i < N; i++) begin m_flag[i] = 0; m_arm[i] = 0; end
        m_en = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        #(PERIOD/4);
        check("R1 irq after reset", irq, '0);
        check("R1 irq_any after reset", {15'b0, irq_any}, '0);
        @(negedge clk);
        expect_status("R1 status after reset", 16'h0000);
        rd(1); check("R1 enable after reset", last_rd, 16'h0000);

        // R2 / R3 record while disabled, then enable
        pulse(16'hFFFF);
        expect_status("R2 all flags set", 16'hFFFF);
        check("R3 no request while disabled", irq, '0);
        wr(1, 16'h0004);
        check("R3 pending flag drives request", irq, 16'h0004);
        check("R4 combined request", {15'b0, irq_any}, 16'h0001);
        wr(1, 16'hFFFF);
        rd(1); check("R3 enable readback", last_rd, 16'hFFFF);
        idle();

        // R10 accesses without arming: status is read above, so re-init via reset
        rst_n = 0;
        for (int i = 0; i < N; i++) begin m_flag[i] = 0; m_arm[i] = 0; end
        m_en = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        pulse(16'hFFFF);
        wr(0, 16'h0000); wr(2, '0); rd(3); wr(3, '0); wr(4, '0); rd(4); wr(5, '0); rd(5);
        expect_status("R10 unarmed accesses leave flags", 16'hFFFF);

        // R5 write-zero clear; ones keep
        wr(0, 16'h0005);
        expect_status("R5 bits written 0 cleared, 1 kept", 16'hFFF5);
        wr(0, 16'h0000);
        expect_status("R5 remaining write-zero flags cleared", 16'hFFF0);
        // R6
        wr(2, '0);
        expect_status("R6 control write clears source 4", 16'hFFE0);
        // R7
        rd(3);
        expect_status("R7 data read clears source 5", 16'hFFC0);
        // R8
        wr(4, '0);
        expect_status("R8 channel A write clears 6 and 7", 16'hFF00);
        // R9
        rd(4);
        expect_status("R9 channel A read clears 8 to 10", 16'hF800);
        rd(5);
        expect_status("R9 channel B read clears 13 to 15", 16'h1800);
        wr(5, '0);
        expect_status("R8 channel B write clears 11 and 12", 16'h0000);
        // R7 write variant
        pulse(16'h0020); rd(0); wr(3, '0);
        expect_status("R7 data write clears source 5", 16'h0000);

        // R10 status read while flag is 0 does not arm
        rd(0); pulse(16'h0001); wr(0, 16'h0000);
        expect_status("R10 read-at-zero does not arm", 16'h0001);
        wr(0, 16'h0000);
        expect_status("R10 armed by read at one", 16'h0000);

        // R11 set and clear collide
        pulse(16'h0002); rd(0);
        cyc(16'h0002, 1, 1, 0, 16'h0000);
        expect_status("R11 set wins over clear", 16'h0002);
        pulse('0);
        cyc('0, 1, 1, 0, 16'h0000);
        rd(1);
        cyc('0, 1, 1, 0, 16'h0000);
        rd(1);
        // status read above (expect_status) re-armed it; clear, then verify disarm path
        rd(0); wr(0, 16'h0000);
        expect_status("R11 flag clears after new arm", 16'h0000);
        pulse(16'h0080); rd(0);
        cyc(16'h0080, 1, 1, 4, '0);
        wr(4, '0);
        rd(1);
        rd(3);
        wr(4, '0);
        rd(0); check("R11 collision leaves flag unarmed", last_rd, 16'h0080);

        // R12 completed clear disarms
        wr(4, '0);
        pulse(16'h0004); rd(0); wr(0, 16'h0000);
        pulse(16'h0004); wr(0, 16'h0000);
        rd(0); check("R12 no clear without new read", last_rd, 16'h0004);

        // R4 combined off when all disabled
        wr(1, 16'h0000);
        check("R4 combined low when disabled", {15'b0, irq_any}, '0);

        // pseudo-random phase, model-compared each clock
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 600; n++) begin
            logic [N-1:0] e;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            e = lfsr[15:0] & lfsr[31:16] & {lfsr[7:0], lfsr[15:8]};
            cyc(e, lfsr[3] | lfsr[9], lfsr[4], int'(lfsr[12:10]) % 6, lfsr[27:12]);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule